// File: doc/BRIEF.md
# Compare-Based PWM Generator

This block turns a tick stream into a square wave whose period and high time can be set at run time. An 8-bit counter advances once for each tick from a chosen source. The source is picked from a small set of tick inputs, and a run gate can stop the counter. Two equality comparators watch the counter. One marks the last count of a cycle and restarts the counter at zero. The other marks the end of the active phase. The two results set and clear a single output flop, which gives a glitch-free waveform at the clock rate of the block.

Software writes a new period, a new duty value or a new polarity at any moment. The period and duty writes land in holding registers. The holding values, together with the polarity input, reach the live compare registers only on the tick that restarts the counter. Every cycle the output produces is therefore built from one consistent setting.

Top module: `pwm_cmp_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, the live and holding period and duty registers, the live polarity and `pwm_out` all return to 0 at that edge.
- R2: The counter and all live registers change only on a tick, that is a cycle with `run_en` high and `tick_src[tick_sel]` high. With `run_en` low, `pwm_out` holds its value.
- R3: With a live period P of 2 or more, the counter steps 0, 1, ... P-1 and then wraps to 0, so one output cycle lasts P ticks. With P of 0 or 1, the counter stays at 0 and every tick is a wrap.
- R4: With polarity 0, `pwm_out` is 1 exactly while the counter is below the live duty value D. For example, P=10 and D=5 give 5 high ticks out of every 10.
- R5: D=0 holds `pwm_out` at the inactive level. D greater than or equal to P holds it at the active level.
- R6: `per_wr` and `duty_wr` load the holding registers at the clock edge. The holding values move into the live registers only on a wrapping tick. A write in the same cycle as a wrap is used at the following wrap.
- R7: `pol_inv`=1 inverts the waveform, so each cycle starts low and ends high. The input is sampled only on a wrapping tick.
- R8: `tick_sel` picks which bit of `tick_src` drives the counter. A select value of NSRC or above gives no ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Gate for the counter tick |
| tick_sel | input | 2 | Index of the tick source |
| tick_src | input | 4 | Candidate tick inputs, one bit per source |
| per_wr | input | 1 | Write strobe for the period holding register |
| per_wdata | input | 8 | Period value to write |
| duty_wr | input | 1 | Write strobe for the duty holding register |
| duty_wdata | input | 8 | Duty value to write |
| pol_inv | input | 1 | 1 = cycle starts low, 0 = cycle starts high |
| pwm_out | output | 1 | PWM waveform |

## Verification
On every cycle the assertions check several invariants. The counter stays below the live period. It steps by exactly one on a non-wrapping tick and does not move without a tick. The live settings change only on a wrap. The output level always agrees with the counter-versus-duty comparison, and the reset leaves everything at zero. Other properties need a reference model and chosen stimulus, and only the bench scenarios can show them. These are the ratio of high ticks and the rate of rising edges, the postponement of a write to the next boundary, the effect of polarity, the choice of tick source and the degenerate periods 0 and 1.

// File: rtl/pwm_pkg.sv
// Package: pwm_pkg
// Shared constants and types for the compare-based PWM generator.
// Assumes all users take widths from these defaults unless overridden.
package pwm_pkg;

    localparam int DEF_CNT_W = 8;
    localparam int DEF_NSRC  = 4;

    // Encoding of the polarity setting held in the live register.
    typedef enum logic {
        POL_START_HIGH = 1'b0,
        POL_START_LOW  = 1'b1
    } pwm_pol_e;

endpackage

// File: rtl/pwm_tick_sel.sv
// Module: pwm_tick_sel
// Selects one tick source out of NSRC and gates it with a run enable.
// Assumes each source is already a single-cycle pulse or level in the clk
// domain. An out-of-range select yields no tick.
module pwm_tick_sel #(
    parameter int NSRC  = 4,
    parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             run_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [NSRC-1:0]  src,
    output logic             tick
);

    logic [NSRC-1:0] hit;

    // One decoder slice per source: pass the source bit when selected.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = src[g] && (sel == SEL_W'(g));
    end

    // Merge the slices and apply the run gate.
    always_comb begin
        tick = run_en && (|hit);
    end

endmodule

// File: rtl/pwm_counter.sv
// Module: pwm_counter
// Free-running up counter that advances on tick and wraps to zero when it
// reaches the last count of the live period (period - 1). Periods 0 and 1
// hold the counter at zero and make every tick a wrap.
// Assumes act_per changes only on a wrap (driven by pwm_shadow).
module pwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic [CNT_W-1:0] last_cnt;
    logic             short_per;
    logic             per_hit;

    // Period comparator: equality against the last count of the cycle.
    always_comb begin
        last_cnt  = act_per - CNT_W'(1);
        short_per = (act_per <= CNT_W'(1));
        per_hit   = (cnt == last_cnt);
        wrap      = tick && (short_per || per_hit);
    end

    // Counter register: step on tick, clear on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwm_shadow.sv
// Module: pwm_shadow
// Holding registers for period and duty, plus the live compare registers.
// Writes go to holding storage at once. Holding values and the polarity
// input pass to the live registers only when load is high (the wrap tick).
// A write in the load cycle is seen at the next load.
module pwm_shadow #(
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    per_wr,
    input  logic [CNT_W-1:0]        per_wdata,
    input  logic                    duty_wr,
    input  logic [CNT_W-1:0]        duty_wdata,
    input  logic                    pol_in,
    input  logic                    load,
    output logic [CNT_W-1:0]        act_per,
    output logic [CNT_W-1:0]        act_duty,
    output pwm_pkg::pwm_pol_e       act_pol,
    output logic [CNT_W-1:0]        hold_duty
);

    logic [CNT_W-1:0] hold_per;

    // Holding registers: capture software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_per  <= '0;
            hold_duty <= '0;
        end else begin
            if (per_wr)  hold_per  <= per_wdata;
            if (duty_wr) hold_duty <= duty_wdata;
        end
    end

    // Live registers: take the holding values at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_per  <= '0;
            act_duty <= '0;
            act_pol  <= pwm_pkg::POL_START_HIGH;
        end else if (load) begin
            act_per  <= hold_per;
            act_duty <= hold_duty;
            act_pol  <= pwm_pkg::pwm_pol_e'(pol_in);
        end
    end

endmodule

// File: rtl/pwm_out_latch.sv
// Module: pwm_out_latch
// Set/reset output stage. The wrap sets the latch when the incoming duty is
// non-zero. The duty comparator clears it when the next count equals the
// live duty. The stored level is then inverted by the live polarity.
// Assumes nxt_duty is the value the live duty register takes at this wrap.
module pwm_out_latch #(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wrap,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [CNT_W-1:0]    act_duty,
    input  logic [CNT_W-1:0]    nxt_duty,
    input  pwm_pkg::pwm_pol_e   act_pol,
    output logic                pwm_out
);

    logic [CNT_W:0] cnt_inc;
    logic           duty_hit;
    logic           set_q;
    logic           clr_q;
    logic           q;

    // Duty comparator: equality of the next count against the live duty.
    always_comb begin
        cnt_inc  = {1'b0, cnt} + (CNT_W+1)'(1);
        duty_hit = (cnt_inc == {1'b0, act_duty});
        set_q    = wrap && (nxt_duty != '0);
        clr_q    = (wrap && (nxt_duty == '0)) || (tick && !wrap && duty_hit);
    end

    // Latch register: set wins at the boundary, clear ends the active phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set_q) begin
            q <= 1'b1;
        end else if (clr_q) begin
            q <= 1'b0;
        end
    end

    // Output polarity stage.
    always_comb begin
        pwm_out = q ^ (act_pol == pwm_pkg::POL_START_LOW);
    end

endmodule

// File: rtl/pwm_cmp_gen.sv
// Module: pwm_cmp_gen (top)
// Single-channel PWM: tick select, period counter, buffered compare
// registers and set/reset output stage. All inputs are synchronous to clk.
module pwm_cmp_gen #(
    parameter int CNT_W = pwm_pkg::DEF_CNT_W,
    parameter int NSRC  = pwm_pkg::DEF_NSRC,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [SEL_W-1:0] tick_sel,
    input  logic [NSRC-1:0]  tick_src,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             pol_inv,
    output logic             pwm_out
);

    logic              tick;
    logic              wrap;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  act_per;
    logic [CNT_W-1:0]  act_duty;
    logic [CNT_W-1:0]  hold_duty;
    pwm_pkg::pwm_pol_e act_pol;

    pwm_tick_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_tick (
        .run_en (run_en),
        .sel    (tick_sel),
        .src    (tick_src),
        .tick   (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .act_per (act_per),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_wr     (per_wr),
        .per_wdata  (per_wdata),
        .duty_wr    (duty_wr),
        .duty_wdata (duty_wdata),
        .pol_in     (pol_inv),
        .load       (wrap),
        .act_per    (act_per),
        .act_duty   (act_duty),
        .act_pol    (act_pol),
        .hold_duty  (hold_duty)
    );

    pwm_out_latch #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wrap     (wrap),
        .cnt      (cnt),
        .act_duty (act_duty),
        .nxt_duty (hold_duty),
        .act_pol  (act_pol),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm_cmp_gen_chk.sv
// Module: pwm_cmp_gen_chk
// Property checker bound into pwm_cmp_gen. It observes the tick, wrap,
// counter and live registers against the output port.
module pwm_cmp_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_per,
    input logic [CNT_W-1:0] act_duty,
    input logic             act_pol,
    input logic             pwm_out
);

    logic rst_seen;

    // Track whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            assert_reset_state_R1: assert (cnt == '0 && act_per == '0 &&
                                           act_duty == '0 && !act_pol && !pwm_out)
                else $error("reset state wrong");
        end
        rst_seen <= !rst_n;
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && $stable(pwm_out)));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_per >= CNT_W'(2)) |-> (cnt < act_per));

    assert_short_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_per <= CNT_W'(1)) |-> (cnt == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out ^ act_pol) == (cnt < act_duty));

    assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty == '0) |-> (pwm_out == act_pol));

    assert_load_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(act_per) && $stable(act_duty) && $stable(act_pol)));

endmodule

bind pwm_cmp_gen pwm_cmp_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wrap     (wrap),
    .cnt      (cnt),
    .act_per  (act_per),
    .act_duty (act_duty),
    .act_pol  (act_pol),
    .pwm_out  (pwm_out)
);

// File: tb/sim_pwm_cmp_gen.sv
module sim_pwm_cmp_gen;

    localparam int W    = 8;
    localparam int NSRC = 4;
    localparam int SW   = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          run_en;
    logic [SW-1:0] tick_sel;
    logic [NSRC-1:0] tick_src;
    logic          per_wr;
    logic [W-1:0]  per_wdata;
    logic          duty_wr;
    logic [W-1:0]  duty_wdata;
    logic          pol_inv;
    logic          pwm_out;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    cmp_on = 0;
    bit    done   = 0;
    string cur_req = "R1";
    int    phase  = 0;

    // Reference model state
    int m_cnt, m_per, m_duty, m_hper, m_hduty, m_pol, m_exp;

    always #4 clk = ~clk;

    pwm_cmp_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .tick_sel   (tick_sel),
        .tick_src   (tick_src),
        .per_wr     (per_wr),
        .per_wdata  (per_wdata),
        .duty_wr    (duty_wr),
        .duty_wdata (duty_wdata),
        .pol_inv    (pol_inv),
        .pwm_out    (pwm_out)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Tick sources: always, every 2nd, every 3rd, never.
    always @(negedge clk) begin
        phase++;
        tick_src <= {1'b0, (phase % 3) == 0, (phase % 2) == 0, 1'b1};
    end

    // Behavioural reference model, updated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_duty = 0; m_hper = 0; m_hduty = 0; m_pol = 0;
        end else begin
            if (run_en && tick_sel < NSRC && tick_src[tick_sel]) begin
                if (m_per <= 1 || m_cnt == m_per - 1) begin
                    m_cnt = 0; m_per = m_hper; m_duty = m_hduty; m_pol = int'(pol_inv);
                end else begin
                    m_cnt++;
                end
            end
            if (per_wr)  m_hper  = int'(per_wdata);
            if (duty_wr) m_hduty = int'(duty_wdata);
        end
        m_exp = ((m_cnt < m_duty) ? 1 : 0) ^ m_pol;
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) check(cur_req, int'(pwm_out), m_exp);
    end

    task automatic wr(int p, int d);
        @(negedge clk);
        per_wr = 1; per_wdata = W'(p); duty_wr = 1; duty_wdata = W'(d);
        @(negedge clk);
        per_wr = 0; duty_wr = 0;
    endtask

    task automatic count_high(int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            h += int'(pwm_out);
        end
    endtask

    task automatic count_rise(int n, output int r);
        logic prev;
        r = 0;
        @(negedge clk);
        prev = pwm_out;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out && !prev) r++;
            prev = pwm_out;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int h;
        int r;
        rst_n = 0; run_en = 0; tick_sel = 0; tick_src = '0;
        per_wr = 0; per_wdata = '0; duty_wr = 0; duty_wdata = '0; pol_inv = 0;
        repeat (3) @(negedge clk);
        check("R1", int'(pwm_out), 0);
        cmp_on = 1;
        rst_n = 1;

        // R2: no ticks while run_en is low
        cur_req = "R2";
        wr(10, 5);
        repeat (20) @(negedge clk);
        check("R2", int'(pwm_out), 0);

        // R3 / R4: period 10, duty 5
        cur_req = "R3";
        run_en = 1; tick_sel = 0;
        repeat (25) @(negedge clk);
        count_rise(100, r);
        check("R3", r, 10);
        cur_req = "R4";
        count_high(100, h);
        check("R4", h, 50);

        // R6: mid-period write, new values only at the boundary
        cur_req = "R6";
        repeat (3) @(negedge clk);
        wr(6, 2);
        repeat (30) @(negedge clk);
        count_high(60, h);
        check("R6", h, 20);

        // R5: duty 0 and duty above period
        cur_req = "R5";
        wr(6, 0);
        repeat (20) @(negedge clk);
        count_high(30, h);
        check("R5", h, 0);
        wr(6, 200);
        repeat (20) @(negedge clk);
        count_high(30, h);
        check("R5", h, 30);

        // R7: inverted polarity
        cur_req = "R7";
        wr(6, 2);
        pol_inv = 1;
        repeat (20) @(negedge clk);
        count_high(60, h);
        check("R7", h, 40);
        pol_inv = 0;
        repeat (20) @(negedge clk);

        // R8: source select
        cur_req = "R8";
        tick_sel = 1;
        wr(6, 3);
        repeat (40) @(negedge clk);
        count_high(120, h);
        check("R8", h, 60);
        tick_sel = 2;
        repeat (60) @(negedge clk);
        tick_sel = 3;
        repeat (2) @(negedge clk);
        count_high(40, h);
        check("R8", int'(h == 0 || h == 40), 1);

        // R3 degenerate periods
        cur_req = "R3";
        tick_sel = 0;
        wr(1, 1);
        repeat (10) @(negedge clk);
        count_high(20, h);
        check("R3", h, 20);
        wr(0, 0);
        repeat (10) @(negedge clk);
        count_high(20, h);
        check("R3", h, 0);

        // R1: reset in the middle of a run
        cur_req = "R1";
        wr(10, 5);
        repeat (23) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check("R1", int'(pwm_out), 0);
        rst_n = 1;
        repeat (30) @(negedge clk);

        cmp_on = 0;
        finish_run();
    end

endmodule